// File: doc/BRIEF.md
# UART Receive Buffer with Level Interrupt

This block holds received UART characters until the CPU drains them through the data-register read path. Each stored word carries eight data bits and four per-character error bits: framing, parity, break and overrun. A line break enters the buffer through the same push path as any character, as a word with its break bit set. The buffer reports empty and full flags and the free space left for the upstream deserialiser. It also emits one-cycle pulses that set and clear a receive-level interrupt.

A line-control input picks one of two modes at run time. In buffered mode the depth is 16 entries. In holding-register mode the depth is 1 entry. Any change of that input flushes the buffer. Each data read copies the error bits of the word it pops into a status register, and a clear strobe empties that register. A blocking input stops every push. This is used while the transmit side is looped back, so the line input is disconnected from the receive logic.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the buffer is in holding-register mode (depth 1) and empty: `empty_o`=1, `full_o`=0, `free_o`=1, `stat_o`=0, `head_o`=0, and both interrupt pulses are low.
- R2: Words are returned in push order. The word layout is bits [7:0] data, bit 8 framing error, bit 9 parity error, bit 10 break, bit 11 overrun. In buffered mode (`fifo_mode_i`=1) `free_o` equals 16 minus the fill count, and the storage index wraps modulo 16.
- R3: `full_o` rises when the fill count reaches the effective depth, which is 16 in buffered mode and 1 in holding mode. A push while full and without a pop in the same cycle is dropped, and it leaves the contents, `free_o` and the pulses unchanged.
- R4: `head_o` shows the oldest word. A pop advances the buffer only when it is non-empty. Every pop lowers `full_o` unless a push in the same cycle refills the buffer. `empty_o` rises when the count reaches zero.
- R5: `irq_set_o` pulses high for exactly one cycle, in the cycle after a push edge, when the accepted push makes the fill count equal to the trigger level. The trigger level is 1.
- R6: `irq_clr_o` pulses high for one cycle after a pop edge when the fill count after the pop plus one equals the trigger level. This includes a pop of an empty buffer.
- R7: Any change of `fifo_mode_i` relative to the previously registered mode empties the buffer (`empty_o`=1, `full_o`=0, free space equal to the new depth). A push or pop in that same cycle is ignored.
- R8: A pop copies bits [11:8] of the head word into `stat_o`. `stat_clr_i` zeroes `stat_o`. When both occur in the same cycle, the copy wins.
- R9: While `rx_block_i` is high, pushes are ignored, including break words.
- R10: When a push and a pop occur in the same cycle, the pop is applied first. A push into a full buffer is therefore accepted when a pop accompanies it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Store `push_word_i` this cycle |
| push_word_i | input | 12 | Incoming word: data [7:0], error bits [11:8] |
| pop_i | input | 1 | Data-register read strobe |
| fifo_mode_i | input | 1 | 1 = 16-entry buffered mode, 0 = single holding register |
| rx_block_i | input | 1 | Ignore all pushes while high |
| stat_clr_i | input | 1 | Write strobe that clears the receive status |
| head_o | output | 12 | Oldest stored word |
| empty_o | output | 1 | Buffer empty flag |
| full_o | output | 1 | Buffer full flag |
| free_o | output | 5 | Effective depth minus fill count |
| irq_set_o | output | 1 | One-cycle receive-interrupt set pulse |
| irq_clr_o | output | 1 | One-cycle receive-interrupt clear pulse |
| stat_o | output | 4 | Error bits of the last popped word |

## Verification
The main path is tried with lone pushes into an empty buffer and with pushes that stack above the trigger. This separates a set pulse at the trigger crossing from no pulse above it. It is also tried with lone pops, which separate the last-entry pop that clears the interrupt from an earlier one that does not, and with a push and a pop in one cycle. That last pattern shows that the pop is ordered first, both at low fill and at full.

Directed runs fill all 16 entries across the wrap point and push once more to prove the drop. They repeat the drop in holding mode with one entry. They toggle the mode with data present and with a push in the same cycle. They push under blocking, pop an empty buffer, and issue a pop together with a status clear.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
    localparam int DATA_W = 8;
    localparam int ERR_W  = 4;
    localparam int WORD_W = DATA_W + ERR_W;

    // error bit positions inside the error field
    localparam int ERR_FRAME = 0;
    localparam int ERR_PAR   = 1;
    localparam int ERR_BRK   = 2;
    localparam int ERR_OVR   = 3;
endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl #(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             mode_i,
    input  logic             block_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic             pop_fire_o,
    output logic [CNT_W-1:0] free_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             set_o,
    output logic             clr_o
);
    typedef struct packed {
        logic             mode;
        logic [PTR_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
        logic             empty;
        logic             full;
        logic             set;
        logic             clr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [CNT_W-1:0] depth_eff;
    logic [PTR_W-1:0] mask;
    logic             toggle;
    logic             pop_nz;
    logic [CNT_W-1:0] cnt_after_pop;
    logic [PTR_W-1:0] pos_after_pop;
    logic             accept;
    logic [CNT_W-1:0] cnt_after_push;

    always_comb begin
        depth_eff      = st_q.mode ? CNT_W'(DEPTH) : CNT_W'(1);
        mask           = st_q.mode ? PTR_W'(DEPTH - 1) : '0;
        toggle         = (mode_i != st_q.mode);
        // pop is ordered ahead of push within one cycle
        pop_nz         = pop_i && (st_q.cnt != '0);
        cnt_after_pop  = st_q.cnt - CNT_W'(pop_nz);
        pos_after_pop  = pop_nz ? ((st_q.pos + PTR_W'(1)) & mask) : st_q.pos;
        accept         = push_i && !block_i && (cnt_after_pop < depth_eff) && !toggle;
        cnt_after_push = cnt_after_pop + CNT_W'(accept);

        st_d       = st_q;
        st_d.set   = 1'b0;
        st_d.clr   = 1'b0;
        wr_en_o    = 1'b0;
        wr_idx_o   = (pos_after_pop + cnt_after_pop[PTR_W-1:0]) & mask;
        pop_fire_o = 1'b0;

        if (toggle) begin
            st_d.mode  = mode_i;
            st_d.pos   = '0;
            st_d.cnt   = '0;
            st_d.empty = 1'b1;
            st_d.full  = 1'b0;
        end else begin
            pop_fire_o = pop_i;
            wr_en_o    = accept;
            st_d.pos   = pos_after_pop;
            st_d.cnt   = cnt_after_push;
            st_d.clr   = pop_i && ((CNT_W + 1)'(cnt_after_pop) + (CNT_W + 1)'(1)
                                   == (CNT_W + 1)'(TRIG));
            st_d.set   = accept && (cnt_after_push == CNT_W'(TRIG));
            st_d.empty = (cnt_after_push == '0);
            if (accept && cnt_after_push == depth_eff)
                st_d.full = 1'b1;
            else if (pop_i)
                st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: 1'b0, pos: '0, cnt: '0, empty: 1'b1,
                      full: 1'b0, set: 1'b0, clr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx_o = st_q.pos;
    assign free_o   = depth_eff - st_q.cnt;
    assign empty_o  = st_q.empty;
    assign full_o   = st_q.full;
    assign set_o    = st_q.set;
    assign clr_o    = st_q.clr;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= depth_eff);

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.empty && st_q.full));

    assert_set_needs_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.set |-> $past(push_i && !block_i));

    assert_clr_needs_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clr |-> $past(pop_i));

    assert_flush_on_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != $past(st_q.mode)) |-> (st_q.cnt == '0 && st_q.empty && !st_q.full));

    assert_block_no_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(block_i) |-> !st_q.set);
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 12,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [WORD_W-1:0] wr_word_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [WORD_W-1:0] rd_word_o
);
    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_comb begin
            mem_d[e] = mem_q[e];
            if (wr_en_i && wr_idx_i == PTR_W'(e))
                mem_d[e] = wr_word_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[e] <= '0;
            else        mem_q[e] <= mem_d[e];
        end
    end

    assign rd_word_o = mem_q[rd_idx_i];

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mem_q[$past(wr_idx_i)] == $past(wr_word_i)));
endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             copy_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic             clr_i,
    output logic [ERR_W-1:0] stat_o
);
    logic [ERR_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (clr_i)  stat_d = '0;
        if (copy_i) stat_d = err_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i && !copy_i) |-> (stat_q == '0));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [WORD_W-1:0] push_word_i,
    input  logic              pop_i,
    input  logic              fifo_mode_i,
    input  logic              rx_block_i,
    input  logic              stat_clr_i,
    output logic [WORD_W-1:0] head_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [CNT_W-1:0]  free_o,
    output logic              irq_set_o,
    output logic              irq_clr_o,
    output logic [ERR_W-1:0]  stat_o
);
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic             pop_fire;

    rxbuf_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_i),
        .pop_i      (pop_i),
        .mode_i     (fifo_mode_i),
        .block_i    (rx_block_i),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .rd_idx_o   (rd_idx),
        .pop_fire_o (pop_fire),
        .free_o     (free_o),
        .empty_o    (empty_o),
        .full_o     (full_o),
        .set_o      (irq_set_o),
        .clr_o      (irq_clr_o)
    );

    rxbuf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_word_i (push_word_i),
        .rd_idx_i  (rd_idx),
        .rd_word_o (head_o)
    );

    rxbuf_status #(.ERR_W(ERR_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .copy_i (pop_fire),
        .err_i  (head_o[WORD_W-1:DATA_W]),
        .clr_i  (stat_clr_i),
        .stat_o (stat_o)
    );

    assert_pop_copies_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pop_i && fifo_mode_i == $past(fifo_mode_i))
            |-> (stat_o == $past(head_o[WORD_W-1:DATA_W])));
endmodule

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic [11:0] push_word_i = '0;
    logic        pop_i = 1'b0;
    logic        fifo_mode_i = 1'b0;
    logic        rx_block_i = 1'b0;
    logic        stat_clr_i = 1'b0;
    logic [11:0] head_o;
    logic        empty_o, full_o, irq_set_o, irq_clr_o;
    logic [4:0]  free_o;
    logic [3:0]  stat_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_rx_buffer u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_word_i(push_word_i),
        .pop_i(pop_i), .fifo_mode_i(fifo_mode_i), .rx_block_i(rx_block_i),
        .stat_clr_i(stat_clr_i), .head_o(head_o), .empty_o(empty_o),
        .full_o(full_o), .free_o(free_o), .irq_set_o(irq_set_o),
        .irq_clr_o(irq_clr_o), .stat_o(stat_o)
    );

    typedef struct packed {
        logic        push;
        logic [11:0] word;
        logic        pop;
        logic        clr;
        logic [4:0]  free;
        logic        empty;
        logic        full;
        logic [11:0] head;
        logic        set;
        logic        clrp;
        logic [3:0]  stat;
    } vec_t;

    // buffered mode, starting empty at read position 0
    localparam vec_t TBL [8] = '{
        '{1'b1, 12'h041, 1'b0, 1'b0, 5'd15, 1'b0, 1'b0, 12'h041, 1'b1, 1'b0, 4'h0},
        '{1'b1, 12'h142, 1'b0, 1'b0, 5'd14, 1'b0, 1'b0, 12'h041, 1'b0, 1'b0, 4'h0},
        '{1'b0, 12'h000, 1'b1, 1'b0, 5'd15, 1'b0, 1'b0, 12'h142, 1'b0, 1'b0, 4'h0},
        '{1'b0, 12'h000, 1'b1, 1'b0, 5'd16, 1'b1, 1'b0, 12'h000, 1'b0, 1'b1, 4'h1},
        '{1'b0, 12'h000, 1'b0, 1'b1, 5'd16, 1'b1, 1'b0, 12'h000, 1'b0, 1'b0, 4'h0},
        '{1'b1, 12'h400, 1'b1, 1'b0, 5'd15, 1'b0, 1'b0, 12'h400, 1'b1, 1'b1, 4'h0},
        '{1'b1, 12'h8AA, 1'b1, 1'b0, 5'd15, 1'b0, 1'b0, 12'h8AA, 1'b1, 1'b1, 4'h4},
        '{1'b0, 12'h000, 1'b1, 1'b0, 5'd16, 1'b1, 1'b0, 12'h000, 1'b0, 1'b1, 4'h8}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, one rising edge, sample at the next falling edge
    task automatic step(input logic p, input logic [11:0] w, input logic q, input logic c);
        push_i = p; push_word_i = w; pop_i = q; stat_clr_i = c;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; stat_clr_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", 32'(empty_o), 1);
        chk("R1 full", 32'(full_o), 0);
        chk("R1 free", 32'(free_o), 1);
        chk("R1 stat", 32'(stat_o), 0);
        chk("R1 head", 32'(head_o), 0);
        chk("R1 pulses", 32'({irq_set_o, irq_clr_o}), 0);

        // enter buffered mode: flush (R7)
        fifo_mode_i = 1'b1;
        step(0, 0, 0, 0);
        chk("R7 free after mode change", 32'(free_o), 16);

        for (int i = 0; i < 8; i++) begin
            step(TBL[i].push, TBL[i].word, TBL[i].pop, TBL[i].clr);
            chk($sformatf("R2 vec%0d free", i), 32'(free_o), 32'(TBL[i].free));
            chk($sformatf("R4 vec%0d empty", i), 32'(empty_o), 32'(TBL[i].empty));
            chk($sformatf("R3 vec%0d full", i), 32'(full_o), 32'(TBL[i].full));
            chk($sformatf("R2 vec%0d head", i), 32'(head_o), 32'(TBL[i].head));
            chk($sformatf("R5 vec%0d set", i), 32'(irq_set_o), 32'(TBL[i].set));
            chk($sformatf("R6 vec%0d clr", i), 32'(irq_clr_o), 32'(TBL[i].clrp));
            chk($sformatf("R8 vec%0d stat", i), 32'(stat_o), 32'(TBL[i].stat));
        end

        // fill across the wrap point, then overflow (R2, R3)
        for (int i = 0; i < 16; i++) begin
            step(1, 12'(12'h010 + i), 0, 0);
            chk("R2 free while filling", 32'(free_o), 32'(15 - i));
        end
        chk("R3 full at 16", 32'(full_o), 1);
        step(1, 12'h0FF, 0, 0);
        chk("R3 dropped push free", 32'(free_o), 0);
        chk("R3 dropped push head", 32'(head_o), 12'h010);
        chk("R3 dropped push no set", 32'(irq_set_o), 0);
        for (int i = 0; i < 16; i++) begin
            chk("R2 order", 32'(head_o), 32'(12'h010 + i));
            step(0, 0, 1, 0);
            if (i == 0) chk("R4 full drops on pop", 32'(full_o), 0);
        end
        chk("R4 empty after drain", 32'(empty_o), 1);

        // simultaneous push and pop at full (R10)
        for (int i = 0; i < 16; i++) step(1, 12'(12'h020 + i), 0, 0);
        step(1, 12'h3CC, 1, 0);
        chk("R10 free stays 0", 32'(free_o), 0);
        chk("R10 full stays", 32'(full_o), 1);
        chk("R10 head advanced", 32'(head_o), 12'h021);
        for (int i = 0; i < 15; i++) step(0, 0, 1, 0);
        chk("R10 pushed word kept", 32'(head_o), 12'h3CC);
        step(0, 0, 1, 0);
        chk("R10 drained", 32'(empty_o), 1);

        // holding-register mode (R3, R7)
        fifo_mode_i = 1'b0;
        step(1, 12'h0EE, 0, 0);
        chk("R7 flush to depth 1", 32'(free_o), 1);
        chk("R7 push in toggle cycle ignored", 32'(empty_o), 1);
        step(1, 12'h055, 0, 0);
        chk("R3 single full", 32'(full_o), 1);
        chk("R5 single set", 32'(irq_set_o), 1);
        step(1, 12'h066, 0, 0);
        chk("R3 single drop free", 32'(free_o), 0);
        chk("R3 single drop head", 32'(head_o), 12'h055);
        step(0, 0, 1, 0);
        chk("R4 single empty", 32'(empty_o), 1);
        chk("R4 single full clear", 32'(full_o), 0);
        chk("R6 single clr", 32'(irq_clr_o), 1);

        // flush with data present (R7)
        step(1, 12'h077, 0, 0);
        chk("R3 single refill", 32'(full_o), 1);
        fifo_mode_i = 1'b1;
        step(1, 12'h099, 0, 0);
        chk("R7 flushed empty", 32'(empty_o), 1);
        chk("R7 flushed full", 32'(full_o), 0);
        chk("R7 flushed free", 32'(free_o), 16);
        chk("R7 no set", 32'(irq_set_o), 0);

        // blocking (R9)
        rx_block_i = 1'b1;
        step(1, 12'h4AB, 0, 0);
        chk("R9 blocked free", 32'(free_o), 16);
        chk("R9 blocked empty", 32'(empty_o), 1);
        chk("R9 blocked no set", 32'(irq_set_o), 0);
        rx_block_i = 1'b0;

        // pop of empty buffer (R6)
        step(0, 0, 1, 0);
        chk("R6 empty pop clr", 32'(irq_clr_o), 1);
        chk("R6 empty pop free", 32'(free_o), 16);

        // copy beats clear (R8)
        step(1, 12'h2AB, 0, 0);
        step(0, 0, 1, 1);
        chk("R8 copy wins", 32'(stat_o), 2);
        step(0, 0, 0, 1);
        chk("R8 clear", 32'(stat_o), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule